// File: doc/BRIEF.md
# Double-Rate Pixel Deinterleaver for Two Panels

This block sits between a display controller and two identical RGB565 panels. The controller drives one parallel stream at twice the pixel rate of a single panel. Its lines are twice as long as a panel line, and pixels for the two panels take turns. The block pairs each pixel for panel A with the pixel for panel B that follows it. It presents both pixels together on two output buses, each with its own copy of the sync and data-enable signals. It also drives a pixel clock at half the input rate, so that each panel sees one pixel per native clock with its usual timing.

A single register holds the panel A pixel until its partner arrives. The pair then loads both output stages on the same input edge, and the sync and enable levels load on that edge too. Data and control therefore share one latency. The output clock comes straight from the internal pair-phase register. It is low while the first pixel of a pair is on the input and high while the second is. Each rising edge of the output clock therefore falls one input cycle after the data last changed. A rising data enable restarts the pairing. If that restart lands mid-pair, the clock's high phase is stretched rather than cut short.

Top module: `dpx_deinterleave`

## Requirements
- R1: While rst_ni is low, pclk_o and every panel output (data, hsync, vsync, enable on both panels) are 0.
- R2: pclk_o runs continuously. Each low phase lasts exactly one input clock cycle. Each high phase lasts exactly one input clock cycle, except in the case of R7.
- R3: Counting from the first input cycle in which de_i is high after being low, the active pixels at even positions (0, 2, 4, ...) go to panel A (a_pix_o), and the pixel that follows each of them goes to panel B (b_pix_o).
- R4: Panel outputs change only on the input clock edge at which pclk_o falls. They hold their value through the cycle in which pclk_o is low and across its rising edge.
- R5: A pair whose second pixel is on the input during cycle c appears on the outputs from cycle c+1. Until a line's first pair has completed, the outputs still show blanking.
- R6: On each panel, the hsync, vsync and enable outputs take the input levels seen in the second input cycle of each pair. A level present only in the first cycle of a pair is not passed on. Both panels always carry identical sync and enable levels.
- R7: If de_i rises in a cycle in which pclk_o is high, pclk_o stays high for one more cycle. Pairing restarts, so the first pixel of the line still goes to panel A.
- R8: Whenever a panel's output enable is low, both panel data outputs are 0.
- R9: If a line has an odd number of active pixels, the last pixel is dropped. No output cycle with the enable high is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Double-rate input pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | PIX_W (16) | Interleaved RGB565 input pixel |
| hs_i | input | 1 | Input horizontal sync |
| vs_i | input | 1 | Input vertical sync |
| de_i | input | 1 | Input data enable |
| pclk_o | output | 1 | Half-rate panel pixel clock; panels sample on its rising edge |
| a_pix_o | output | PIX_W (16) | Panel A pixel data |
| a_hs_o | output | 1 | Panel A horizontal sync |
| a_vs_o | output | 1 | Panel A vertical sync |
| a_de_o | output | 1 | Panel A data enable |
| b_pix_o | output | PIX_W (16) | Panel B pixel data |
| b_hs_o | output | 1 | Panel B horizontal sync |
| b_vs_o | output | 1 | Panel B vertical sync |
| b_de_o | output | 1 | Panel B data enable |

## Verification
The tests cover two cases of line alignment. In the first, the enable rises while the output clock is low. In the second, it rises while the clock is high. Comparing them separates a correct restart of the pairing from one that merely follows a free-running divider. With the second case, it also exposes a clock that emits a runt high phase.

An even-length line of distinct ramp values shows whether each pixel goes to the right panel, with the right latency, and stays stable between updates. An odd-length line shows whether the lone final pixel is dropped.

The sync tests apply pulses in several placements:
- a pulse covering both cycles of a pair, to show that it is passed on;
- a pulse confined to the first cycle of a pair, to show that it is ignored;
- non-zero data during blanking, to show that the output data buses are forced to zero.

// File: rtl/dpx_pkg.sv
`timescale 1ns/1ps
package dpx_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } dpx_sync_t;
endpackage

// File: rtl/dpx_phase.sv
`timescale 1ns/1ps
// Pair phase tracker; slot_o=1 marks the second pixel of a pair.
module dpx_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic de_i,
  output logic slot_o,
  output logic pclk_o
);
  logic de_q, ph_q, de_rise;

  assign de_rise = de_i & ~de_q;
  // a rising enable always starts a new pair
  assign slot_o  = de_rise ? 1'b0 : ph_q;
  assign pclk_o  = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      de_q <= de_i;
      ph_q <= ~slot_o;
    end
  end
endmodule

// File: rtl/dpx_hold.sv
`timescale 1ns/1ps
// Holds the first pixel of a pair until its partner arrives.
module dpx_hold #(
  parameter int PIX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (load_i) hold_o <= pix_i;
  end
endmodule

// File: rtl/dpx_lane.sv
`timescale 1ns/1ps
// Per-panel output stage; data forced to zero during blanking.
module dpx_lane
  import dpx_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIX_W-1:0] pix_i,
  input  dpx_sync_t        sync_i,
  output logic [PIX_W-1:0] pix_o,
  output dpx_sync_t        sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o  <= '0;
      sync_o <= '0;
    end else if (load_i) begin
      pix_o  <= sync_i.de ? pix_i : '0;
      sync_o <= sync_i;
    end
  end
endmodule

// File: rtl/dpx_deinterleave.sv
`timescale 1ns/1ps
module dpx_deinterleave
  import dpx_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic             de_i,
  output logic             pclk_o,
  output logic [PIX_W-1:0] a_pix_o,
  output logic             a_hs_o,
  output logic             a_vs_o,
  output logic             a_de_o,
  output logic [PIX_W-1:0] b_pix_o,
  output logic             b_hs_o,
  output logic             b_vs_o,
  output logic             b_de_o
);
  localparam int NUM_LANES = 2;

  logic                               slot;
  logic [PIX_W-1:0]                   hold_q;
  logic [NUM_LANES-1:0][PIX_W-1:0]    lane_in;
  logic [NUM_LANES-1:0][PIX_W-1:0]    lane_pix;
  dpx_sync_t                          lane_sync [NUM_LANES];
  dpx_sync_t                          sync_in;

  assign sync_in = '{hs: hs_i, vs: vs_i, de: de_i};

  dpx_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .de_i   (de_i),
    .slot_o (slot),
    .pclk_o (pclk_o)
  );

  dpx_hold #(.PIX_W(PIX_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~slot),
    .pix_i  (pix_i),
    .hold_o (hold_q)
  );

  // lane 0 takes the held first pixel, lane 1 the live second pixel
  assign lane_in[0] = hold_q;
  assign lane_in[1] = pix_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dpx_lane #(.PIX_W(PIX_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (slot),
      .pix_i  (lane_in[g]),
      .sync_i (sync_in),
      .pix_o  (lane_pix[g]),
      .sync_o (lane_sync[g])
    );
  end

  assign a_pix_o = lane_pix[0];
  assign a_hs_o  = lane_sync[0].hs;
  assign a_vs_o  = lane_sync[0].vs;
  assign a_de_o  = lane_sync[0].de;
  assign b_pix_o = lane_pix[1];
  assign b_hs_o  = lane_sync[1].hs;
  assign b_vs_o  = lane_sync[1].vs;
  assign b_de_o  = lane_sync[1].de;
endmodule

// File: rtl/dpx_deinterleave_chk.sv
`timescale 1ns/1ps
module dpx_deinterleave_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PIX_W-1:0] pix_i,
  input logic             hs_i,
  input logic             vs_i,
  input logic             de_i,
  input logic             pclk_o,
  input logic [PIX_W-1:0] a_pix_o,
  input logic             a_hs_o,
  input logic             a_vs_o,
  input logic             a_de_o,
  input logic [PIX_W-1:0] b_pix_o,
  input logic             b_hs_o,
  input logic             b_vs_o,
  input logic             b_de_o
);
  logic de_prev;
  logic de_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) de_prev <= 1'b0;
    else         de_prev <= de_i;
  end
  assign de_rise = de_i & ~de_prev;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!pclk_o && !a_de_o && !b_de_o && a_pix_o == '0 && b_pix_o == '0)); // R1

  AST_PCLK_LOW_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pclk_o |=> pclk_o); // R2

  AST_PCLK_HIGH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_o && !de_rise) |=> !pclk_o); // R2

  AST_PCLK_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_o && de_rise) |=> pclk_o); // R7

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pclk_o |=> $stable({a_pix_o, b_pix_o, a_hs_o, a_vs_o, a_de_o})); // R4

  AST_PAIR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_o && !de_rise && de_i) |=> (b_pix_o == $past(pix_i) && a_pix_o == $past(pix_i, 2))); // R3

  AST_SYNC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_o && !de_rise) |=> (a_de_o == $past(de_i) && a_hs_o == $past(hs_i) && a_vs_o == $past(vs_i))); // R6

  AST_LANES_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {a_hs_o, a_vs_o, a_de_o} == {b_hs_o, b_vs_o, b_de_o}); // R6

  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_de_o |-> (a_pix_o == '0 && b_pix_o == '0)); // R8
endmodule

bind dpx_deinterleave dpx_deinterleave_chk #(.PIX_W(PIX_W)) chk_i (.*);

// File: tb/dpx_deinterleave_tb_top.sv
`timescale 1ns/1ps
module dpx_deinterleave_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pix_i = '0;
  logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
  logic        pclk_o;
  logic [15:0] a_pix_o, b_pix_o;
  logic        a_hs_o, a_vs_o, a_de_o, b_hs_o, b_vs_o, b_de_o;

  int   n_chk = 0;
  int   n_err = 0;
  logic pclk_now;

  always #2.5 clk_i = ~clk_i;

  dpx_deinterleave #(.PIX_W(16)) dut_i (
    .clk_i, .rst_ni, .pix_i, .hs_i, .vs_i, .de_i, .pclk_o,
    .a_pix_o, .a_hs_o, .a_vs_o, .a_de_o,
    .b_pix_o, .b_hs_o, .b_vs_o, .b_de_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // outputs are all registered, so reading them right after driving is safe
  task automatic tick(input logic [15:0] p, input logic h, input logic v, input logic d);
    @(negedge clk_i);
    pclk_now = pclk_o;
    pix_i = p; hs_i = h; vs_i = v; de_i = d;
  endtask

  // leave the bench so that the next tick runs in a cycle with pclk_o == w
  task automatic align(input logic w);
    for (int i = 0; i < 4; i++) begin
      tick(16'h0, 1'b0, 1'b0, 1'b0);
      if (pclk_now == !w) break;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      tick(16'hFFFF, 1'b1, 1'b1, 1'b1);
      chk("R1", "pclk", pclk_o, 0);
      chk("R1", "pix", {a_pix_o, b_pix_o}, 0);
      chk("R1", "sync", {a_hs_o, a_vs_o, a_de_o, b_hs_o, b_vs_o, b_de_o}, 0);
    end
    tick(16'h0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic t_clock();
    logic prev;
    tick(16'h0, 1'b0, 1'b0, 1'b0);
    prev = pclk_now;
    for (int i = 0; i < 10; i++) begin
      tick(16'h0, 1'b0, 1'b0, 1'b0);
      chk("R2", "pclk toggles each cycle", pclk_now, !prev);
      prev = pclk_now;
    end
  endtask

  task automatic t_line(input logic w, input int n, input logic [15:0] base);
    align(w);
    for (int j = 0; j < n + 3; j++) begin
      int o;
      tick((j < n) ? base + 16'(j) : 16'h0, 1'b0, 1'b0, j < n);
      if (j == 0)      chk(w ? "R7" : "R2", "pclk at line start", pclk_now, w);
      else if (j == 1) chk(w ? "R7" : "R2", "pclk second cycle", pclk_now, 1);
      else             chk("R4", "pclk phase vs data", pclk_now, j % 2);
      if (j < 2) begin
        chk("R5", "no pair yet", {a_de_o, b_de_o}, 0);
        chk("R5", "blank data", {a_pix_o, b_pix_o}, 0);
      end else begin
        o = ((j - 2) / 2) * 2 + 1;
        if (o < n) begin
          chk(w ? "R7" : "R3", "panel A pixel", a_pix_o, int'(base) + o - 1);
          chk(w ? "R7" : "R3", "panel B pixel", b_pix_o, int'(base) + o);
          chk("R5", "enable", {a_de_o, b_de_o}, 2'b11);
        end else begin
          chk(n % 2 ? "R9" : "R5", "enable after line", {a_de_o, b_de_o}, 0);
          chk(n % 2 ? "R9" : "R8", "data after line", {a_pix_o, b_pix_o}, 0);
        end
      end
      chk("R6", "syncs idle", {a_hs_o, a_vs_o, b_hs_o, b_vs_o}, 0);
    end
  endtask

  task automatic t_sync();
    align(1'b0);
    tick(16'h0, 1'b1, 1'b0, 1'b0);
    tick(16'h0, 1'b1, 1'b0, 1'b0);
    tick(16'h0, 1'b0, 1'b1, 1'b0);
    chk("R6", "hsync both slots", {a_hs_o, b_hs_o}, 2'b11);
    tick(16'h0, 1'b0, 1'b1, 1'b0);
    tick(16'h0, 1'b1, 1'b0, 1'b0);
    chk("R6", "vsync both slots", {a_vs_o, b_vs_o, a_hs_o, b_hs_o}, 4'b1100);
    tick(16'h0, 1'b0, 1'b0, 1'b0);
    tick(16'h0, 1'b0, 1'b0, 1'b0);
    chk("R6", "first-slot-only hsync ignored", {a_hs_o, b_hs_o, a_vs_o, b_vs_o}, 0);
  endtask

  task automatic t_blank();
    align(1'b0);
    for (int i = 0; i < 6; i++) begin
      tick(16'hBEEF, 1'b0, 1'b0, 1'b0);
      if (i >= 2) chk("R8", "blank data zero", {a_pix_o, b_pix_o}, 0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_clock();
    t_line(1'b0, 8, 16'h1100);
    t_line(1'b1, 8, 16'h2200);
    t_line(1'b0, 5, 16'h3300);
    t_sync();
    t_blank();
    finish_run();
  end
endmodule